// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a bank of general-purpose input pins, organised as three groups of eight, and turns any toggle on a selected pin into an interrupt request for that pin's group. Each pin must pass two gates before its changes count: its own mask bit, and the enable bit of its group. A qualifying toggle, either rising or falling, sets the group's sticky pending flag. That flag drives the group's request line when the group enable and a global interrupt enable are also high.

Software uses a byte-wide register bus to program the masks and the group enables, and to read and clear the pending flags. A write of one to a flag bit clears it. The processor clears a flag by raising an acknowledge strobe together with the group number of the vector it has taken. The pins are asynchronous to the block's clock, so each one passes through a two-flop synchronizer before change detection. A new change that arrives in the same cycle as a clear takes priority, so no event is lost.

Top module: `pinchg_irq`

## Requirements
- R1: After reset, every mask bit, every group enable bit, every pending flag and every request output is 0.
- R2: A rising or a falling change on a pin whose mask bit and group enable are both 1 sets that group's pending flag. If the pin changes just before clock edge k, the flag reads 1 after edge k+2 and 0 after edge k+1. The flag then stays 1 until it is cleared.
- R3: A pin change has no effect on the flags when that pin's mask bit is 0 or when its group's enable bit is 0.
- R4: Output irq_req[g] is a registered level. It equals flag[g] AND enable[g] AND gie as sampled at the previous clock edge, so it goes high one cycle after the flag is set.
- R5: A bus write to address 0x69 clears each flag whose data bit is 1 and leaves unchanged each flag whose data bit is 0.
- R6: An acknowledge strobe (ack_stb=1) with ack_grp=g clears only the flag of group g. An ack_grp value of 3 clears nothing.
- R7: When a qualifying change would set a flag in the same cycle that a software write or an acknowledge clears it, the flag ends up 1.
- R8: The mask registers are readable and writable at 0x6B (pins 7..0), 0x6C (pins 15..8) and 0x6D (pins 23..16). Bit i of each register belongs to the pin at that group's lowest index plus i.
- R9: Bit 7 of the mask register at 0x6C is reserved. It always reads 0 and ignores writes.
- R10: The group enable register (0x68) and the flag register (0x69) use bit g for group g in bits 2..0, and their bits 7..3 read 0. The enable register can be read and written. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_in | input | 24 | Asynchronous pin levels being watched |
| gie | input | 1 | Global interrupt enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| ack_stb | input | 1 | Vector acknowledge strobe from the processor |
| ack_grp | input | 2 | Group whose vector is being acknowledged |
| irq_req | output | 3 | Per-group interrupt request levels |

## Verification
The hardest case to reach is a collision: a new qualifying pin change lands on exactly the same clock edge as a clear of an already-pending flag. A read from the ports cannot tell this apart from a flag that was simply never cleared. The stimulus first leaves the flag pending, then toggles the pin. It counts the three-edge synchronizer and detection latency so that the clear write, and later the acknowledge, falls on the third edge. Seeing the flag still at 1 afterwards shows that the set took priority over the clear. The bench also checks the latency itself, with a read one edge too early that must still show 0.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int unsigned GROUPS    = 3;
  localparam int unsigned GROUP_W   = 8;
  localparam int unsigned BUS_W     = 8;
  localparam logic [7:0]  A_MASK_LO = 8'h6B;
  localparam logic [7:0]  A_GRP_EN  = 8'h68;
  localparam logic [7:0]  A_FLAGS   = 8'h69;

  // bits that physically exist in each group's mask register
  function automatic logic [GROUP_W-1:0] impl_bits(input int g);
    return (g == 1) ? {1'b0, {(GROUP_W-1){1'b1}}} : {GROUP_W{1'b1}};
  endfunction
endpackage

// File: rtl/pcx_sync.sv
module pcx_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/pcx_group.sv
module pcx_group #(
  parameter int unsigned            W    = 8,
  parameter logic [W-1:0]           IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic         grp_en,
  input  logic         gie,
  input  logic         clr,
  output logic [W-1:0] mask_q,
  output logic         set_evt,
  output logic         flag_q,
  output logic         irq_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  // change on any gated pin, either polarity
  assign hit     = (pin_s ^ prev_q) & mask_q & {W{grp_en}};
  assign set_evt = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      mask_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (mask_we) mask_q <= mask_wdata & IMPL;
      // a fresh event outranks any clear in the same cycle
      flag_q <= set_evt | (flag_q & ~clr);
      irq_q  <= flag_q & grp_en & gie;
    end
  end
endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq
  import pcx_pkg::*;
#(
  parameter int unsigned NGRP = GROUPS,
  parameter int unsigned GW   = GROUP_W,
  parameter int unsigned DW   = BUS_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NGRP*GW-1:0]        pins_in,
  input  logic                      gie,
  input  logic                      reg_we,
  input  logic [7:0]                reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  output logic [DW-1:0]             reg_rdata,
  input  logic                      ack_stb,
  input  logic [$clog2(NGRP+1)-1:0] ack_grp,
  output logic [NGRP-1:0]           irq_req
);
  localparam int unsigned NPIN  = NGRP * GW;
  localparam int unsigned SEL_W = $clog2(NGRP + 1);

  logic [NPIN-1:0] pins_s;
  logic [NGRP-1:0] en_q;
  logic [NGRP-1:0] flag_q;
  logic [NGRP-1:0] set_evt;
  logic [NGRP-1:0] clr;
  logic [GW-1:0]   mask_q [NGRP];

  pcx_sync #(.W(NPIN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pins_in),
    .q_sync (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             en_q <= '0;
    else if (reg_we && reg_addr == A_GRP_EN) en_q <= reg_wdata[NGRP-1:0];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic m_we;
    assign m_we   = reg_we && (reg_addr == A_MASK_LO + 8'(g));
    assign clr[g] = (reg_we && reg_addr == A_FLAGS && reg_wdata[g])
                  || (ack_stb && ack_grp == SEL_W'(g));

    pcx_group #(.W(GW), .IMPL(impl_bits(g))) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s     (pins_s[g*GW +: GW]),
      .mask_we   (m_we),
      .mask_wdata(reg_wdata[GW-1:0]),
      .grp_en    (en_q[g]),
      .gie       (gie),
      .clr       (clr[g]),
      .mask_q    (mask_q[g]),
      .set_evt   (set_evt[g]),
      .flag_q    (flag_q[g]),
      .irq_q     (irq_req[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_GRP_EN) reg_rdata[NGRP-1:0] = en_q;
    if (reg_addr == A_FLAGS)  reg_rdata[NGRP-1:0] = flag_q;
    for (int g = 0; g < NGRP; g++) begin
      if (reg_addr == A_MASK_LO + 8'(g)) reg_rdata[GW-1:0] = mask_q[g];
    end
  end
endmodule

// File: rtl/pcx_chk.sv
module pcx_chk #(
  parameter int unsigned NGRP = 3,
  parameter int unsigned DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gie,
  input logic [NGRP-1:0] en_q,
  input logic [NGRP-1:0] flag_q,
  input logic [NGRP-1:0] set_evt,
  input logic [NGRP-1:0] clr,
  input logic [NGRP-1:0] irq_req,
  input logic [7:0]      reg_addr,
  input logic [DW-1:0]   reg_rdata
);
  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    a_r4_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[g] == $past(flag_q[g] & en_q[g] & gie));
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[g] |=> flag_q[g]);
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !set_evt[g]) |=> !flag_q[g]);
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !clr[g]) |=> flag_q[g]);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[g] && !set_evt[g]) |=> !flag_q[g]);
  end

  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h6C) |-> !reg_rdata[7]);
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h68 || reg_addr == 8'h69) |-> (reg_rdata[DW-1:NGRP] == '0));
endmodule

bind pinchg_irq pcx_chk #(.NGRP(NGRP), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gie      (gie),
  .en_q     (en_q),
  .flag_q   (flag_q),
  .set_evt  (set_evt),
  .clr      (clr),
  .irq_req  (irq_req),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata)
);

// File: tb/pinchg_irq_tb.sv
`timescale 1ns/1ps
module pinchg_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic        gie = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        ack_stb = 1'b0;
  logic [1:0]  ack_grp = '0;
  logic [2:0]  irq_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] exp;
    bit         is_irq;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  pinchg_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins), .gie(gie),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_stb(ack_stb), .ack_grp(ack_grp),
    .irq_req(irq_req)
  );

  // monitor: pops each expected item and compares with the port it names
  initial begin
    forever begin
      item_t it;
      logic [7:0] act;
      wait (exp_q.size() != 0);
      it  = exp_q.pop_front();
      act = it.is_irq ? {5'b0, irq_req} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    #1;
    exp_q.push_back('{tag, e, 1'b0});
    wait (exp_q.size() == 0);
  endtask

  task automatic chk_irq(input logic [2:0] e, input string tag);
    #1;
    exp_q.push_back('{tag, {5'b0, e}, 1'b1});
    wait (exp_q.size() == 0);
  endtask

  task automatic ack(input logic [1:0] g);
    ack_stb = 1'b1; ack_grp = g;
    @(negedge clk);
    ack_stb = 1'b0;
  endtask

  // watchdog
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk_reg(8'h6B, 8'h00, "R1 mask0");
    chk_reg(8'h6C, 8'h00, "R1 mask1");
    chk_reg(8'h6D, 8'h00, "R1 mask2");
    chk_reg(8'h68, 8'h00, "R1 enable");
    chk_reg(8'h69, 8'h00, "R1 flags");
    chk_irq(3'b000, "R1 irq");
    tick(1);

    // R8 mask access, R9 reserved bit
    wr(8'h6B, 8'hA5);
    wr(8'h6D, 8'h3C);
    wr(8'h6C, 8'hFF);
    chk_reg(8'h6B, 8'hA5, "R8 mask0 rw");
    chk_reg(8'h6D, 8'h3C, "R8 mask2 rw");
    chk_reg(8'h6C, 8'h7F, "R9 reserved bit reads 0");
    // R10 enable register width, unmapped address
    wr(8'h68, 8'hFF);
    chk_reg(8'h68, 8'h07, "R10 enable upper bits");
    chk_reg(8'h70, 8'h00, "R10 unmapped reads 0");

    wr(8'h6B, 8'h01);
    wr(8'h6C, 8'h00);
    wr(8'h6D, 8'h00);
    gie = 1'b1;
    tick(1);

    // R3 pin with mask 0 ignored
    pins[1] = 1'b1;
    tick(4);
    chk_reg(8'h69, 8'h00, "R3 masked pin ignored");
    chk_irq(3'b000, "R3 no irq");

    // R2 rising edge latency, R4 request one cycle later
    pins[0] = 1'b1;
    tick(2);
    chk_reg(8'h69, 8'h00, "R2 flag not yet set");
    tick(1);
    chk_reg(8'h69, 8'h01, "R2 flag on rise");
    chk_irq(3'b000, "R4 irq lags flag");
    tick(1);
    chk_irq(3'b001, "R4 irq asserted");

    // R5 write-0 keeps, write-1 clears
    wr(8'h69, 8'h00);
    chk_reg(8'h69, 8'h01, "R5 write 0 keeps flag");
    wr(8'h69, 8'h01);
    chk_reg(8'h69, 8'h00, "R5 write 1 clears flag");
    tick(1);
    chk_irq(3'b000, "R4 irq drops after clear");

    // R2 falling edge
    pins[0] = 1'b0;
    tick(3);
    chk_reg(8'h69, 8'h01, "R2 flag on fall");

    // R6 acknowledge of other groups leaves group 0 pending
    ack(2'd2);
    ack(2'd3);
    chk_reg(8'h69, 8'h01, "R6 other ack ignored");
    ack(2'd0);
    chk_reg(8'h69, 8'h00, "R6 ack clears group 0");

    // R3 group enable off
    wr(8'h68, 8'h06);
    pins[0] = 1'b1;
    tick(4);
    chk_reg(8'h69, 8'h00, "R3 group disabled ignored");
    wr(8'h68, 8'h07);
    tick(4);

    // R4 global enable gates the request
    gie = 1'b0;
    pins[0] = 1'b0;
    tick(5);
    chk_reg(8'h69, 8'h01, "R4 flag with gie low");
    chk_irq(3'b000, "R4 irq blocked by gie");
    gie = 1'b1;
    tick(1);
    chk_irq(3'b001, "R4 irq after gie");
    wr(8'h69, 8'h01);
    tick(1);

    // R8 pin-to-bit mapping for groups 1 and 2
    wr(8'h6C, 8'h04);
    wr(8'h6D, 8'h80);
    pins[10] = 1'b1;
    pins[9]  = 1'b1;
    tick(4);
    chk_reg(8'h69, 8'h02, "R8 pin 10 to group 1");
    chk_irq(3'b010, "R8 group 1 irq");
    pins[23] = 1'b1;
    tick(4);
    chk_reg(8'h69, 8'h06, "R8 pin 23 to group 2");
    chk_irq(3'b110, "R8 group 2 irq");
    wr(8'h69, 8'h07);
    chk_reg(8'h69, 8'h00, "R5 clear all");
    tick(1);

    // R7 set wins over write clear in the same cycle
    pins[0] = 1'b1;
    tick(4);
    pins[0] = 1'b0;
    tick(2);
    wr(8'h69, 8'h01);
    chk_reg(8'h69, 8'h01, "R7 set beats write clear");
    // R7 set wins over acknowledge
    pins[0] = 1'b1;
    tick(2);
    ack(2'd0);
    chk_reg(8'h69, 8'h01, "R7 set beats ack");
    ack(2'd0);
    chk_reg(8'h69, 8'h00, "R6 plain ack clears");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule